// File: doc/BRIEF.md
# Multi-core IRQ/FIQ interrupt router

This block gathers every interrupt that can reach a cluster of four processor cores and steers each one to either the normal-priority (IRQ) or fast (FIQ) line of a chosen core. Each core has four generic-timer lines and four mailbox-pending flags of its own. The cluster also shares one peripheral IRQ/FIQ pair and one local-timer interrupt. The mailbox storage and the timer counters sit outside the block, and their state arrives here as level flags.

Software programs the router through a word-wide register port. Two routing registers pick the destination core for the shared sources. For each core, one control byte covers its timer lines and another covers its mailboxes. For every core the block rebuilds two source words from scratch each cycle: one lists what is pending on its IRQ and one lists what is pending on its FIQ. Software can read both words to find the cause of an interrupt. Each core's output line is the registered OR of its word.

Top module: `core_irq_steer`

## Requirements
- R1: After reset the routing and control registers read zero, both source words of every core read zero, and every `core_irq` and `core_fiq` output is low.
- R2: In a core's timer control byte (offset 0x40 + 4*core), bit n enables IRQ delivery of timer line n and bit n+4 enables FIQ delivery. A line with both bits set goes to FIQ only. A line with neither bit set is masked. Timer line n sets source bit n.
- R3: The mailbox control byte (offset 0x50 + 4*core) applies the same IRQ/FIQ rule to mailbox flag n of that core, and mailbox n sets source bit 4+n.
- R4: The peripheral route register sits at offset 0x0C. Bits 1:0 pick the core that receives the shared IRQ and bits 3:2 pick the core that receives the shared FIQ. Each sets source bit 8 in the matching word, and a read returns (fiq_core<<2)|irq_core.
- R5: The local-timer route register sits at offset 0x24. Bits 1:0 pick the core, and bit 2 selects FIQ when set and IRQ when clear. The interrupt sets source bit 11.
- R6: Writes to the timer and mailbox control registers keep only the low 8 bits.
- R7: A core's `core_irq` (or `core_fiq`) is high exactly one clock after its IRQ (or FIQ) source word, read at offset 0x60 + 4*core (or 0x70 + 4*core), is nonzero.
- R8: The source words are read-only, and writes to them change nothing. Accesses to unmapped or unaligned offsets are ignored, and such reads return zero. Source bits 9, 10 and 12 to 31 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tmr_lvl | input | 16 | Timer lines, bit 4*core+n is line n of that core |
| mbox_pend | input | 16 | Mailbox flags, bit 4*core+n is mailbox n of that core |
| periph_irq | input | 1 | Shared peripheral IRQ |
| periph_fiq | input | 1 | Shared peripheral FIQ |
| ltimer_irq | input | 1 | Local-timer interrupt |
| core_irq | output | 4 | IRQ line per core |
| core_fiq | output | 4 | FIQ line per core |

## Verification
Several properties are checked on every cycle. The assertions confirm that each output follows its source word with one clock of delay. They confirm that a timer line with both enables set reaches FIQ and never IRQ. They also confirm that the shared peripheral and local-timer interrupts land in the word of the core chosen by the route registers, and that a write to a source-word offset leaves the control registers untouched. Other behaviours can only be shown by the bench scenarios: the byte masking on readback, the packing of the route readback, zero reads of unmapped offsets, and the full mapping from control patterns to output lines.

// File: rtl/core_irq_steer.sv
module core_irq_steer #(
  parameter int NCORE = 4,
  parameter int NSRC  = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic [NCORE*NSRC-1:0]  tmr_lvl,
  input  logic [NCORE*NSRC-1:0]  mbox_pend,
  input  logic                   periph_irq,
  input  logic                   periph_fiq,
  input  logic                   ltimer_irq,
  output logic [NCORE-1:0]       core_irq,
  output logic [NCORE-1:0]       core_fiq
);
  localparam int CW     = $clog2(NCORE);
  localparam int CTLW   = 2 * NSRC;
  localparam int GW     = AW - CW - 2;
  localparam int B_MBOX = NSRC;
  localparam int B_PER  = 2 * NSRC;
  localparam int B_LT   = 2 * NSRC + 3;
  localparam logic [AW-1:0] A_PROUTE  = AW'(8'h0C);
  localparam logic [AW-1:0] A_LTROUTE = AW'(8'h24);
  localparam logic [GW-1:0] G_TCTL = GW'(4);
  localparam logic [GW-1:0] G_MCTL = GW'(5);
  localparam logic [GW-1:0] G_ISRC = GW'(6);
  localparam logic [GW-1:0] G_FSRC = GW'(7);

  logic [CW-1:0]   pirq_core, pfiq_core;
  logic [CW:0]     lt_route;
  logic [CTLW-1:0] tctl [NCORE];
  logic [CTLW-1:0] mctl [NCORE];
  logic [DW-1:0]   isrc [NCORE];
  logic [DW-1:0]   fsrc [NCORE];

  wire          aligned = (addr[1:0] == 2'b00);
  wire [GW-1:0] grp     = addr[AW-1:CW+2];
  wire [CW-1:0] idx     = addr[CW+1:2];
  wire          unused_wdata = ^wdata[DW-1:CTLW];

  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      isrc[c] = '0;
      fsrc[c] = '0;
      for (int j = 0; j < NSRC; j++) begin
        if (tmr_lvl[c*NSRC+j]) begin
          if (tctl[c][j+NSRC])  fsrc[c][j] = 1'b1;
          else if (tctl[c][j])  isrc[c][j] = 1'b1;
        end
        if (mbox_pend[c*NSRC+j]) begin
          if (mctl[c][j+NSRC])  fsrc[c][B_MBOX+j] = 1'b1;
          else if (mctl[c][j])  isrc[c][B_MBOX+j] = 1'b1;
        end
      end
      if (periph_irq && pirq_core == CW'(c)) isrc[c][B_PER] = 1'b1;
      if (periph_fiq && pfiq_core == CW'(c)) fsrc[c][B_PER] = 1'b1;
      if (ltimer_irq && lt_route[CW-1:0] == CW'(c)) begin
        if (lt_route[CW]) fsrc[c][B_LT] = 1'b1;
        else              isrc[c][B_LT] = 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (addr == A_PROUTE)       rdata = DW'({pfiq_core, pirq_core});
      else if (addr == A_LTROUTE) rdata = DW'(lt_route);
      else begin
        case (grp)
          G_TCTL:  rdata = DW'(tctl[idx]);
          G_MCTL:  rdata = DW'(mctl[idx]);
          G_ISRC:  rdata = isrc[idx];
          G_FSRC:  rdata = fsrc[idx];
          default: rdata = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pirq_core <= '0;
      pfiq_core <= '0;
      lt_route  <= '0;
      for (int c = 0; c < NCORE; c++) begin
        tctl[c] <= '0;
        mctl[c] <= '0;
      end
    end else if (wr_en && aligned) begin
      if (addr == A_PROUTE) begin
        pirq_core <= wdata[CW-1:0];
        pfiq_core <= wdata[2*CW-1:CW];
      end else if (addr == A_LTROUTE) begin
        lt_route <= wdata[CW:0];
      end else if (grp == G_TCTL) begin
        tctl[idx] <= wdata[CTLW-1:0];
      end else if (grp == G_MCTL) begin
        mctl[idx] <= wdata[CTLW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_irq <= '0;
      core_fiq <= '0;
    end else begin
      for (int c = 0; c < NCORE; c++) begin
        core_irq[c] <= |isrc[c];
        core_fiq[c] <= |fsrc[c];
      end
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_chk
    a_r7_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (|isrc[c]) |=> core_irq[c]);
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(|isrc[c]) |=> !core_irq[c]);
    a_r7_fiq_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (|fsrc[c]) |=> core_fiq[c]);
    a_r2_fiq_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_lvl[c*NSRC] && tctl[c][NSRC] && tctl[c][0]) |-> (fsrc[c][0] && !isrc[c][0]));
    a_r4_periph_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_irq && pirq_core == CW'(c)) |-> isrc[c][B_PER]);
    a_r5_lt_fiq_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (ltimer_irq && lt_route == {1'b1, CW'(c)}) |-> (fsrc[c][B_LT] && !isrc[c][B_LT]));
    a_r8_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (grp == G_ISRC || grp == G_FSRC)) |=> ($stable(tctl[c]) && $stable(mctl[c])));
  end
endmodule

// File: tb/core_irq_steer_test.sv
module core_irq_steer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] tmr_lvl = '0;
  logic [15:0] mbox_pend = '0;
  logic        periph_irq = 1'b0, periph_fiq = 1'b0, ltimer_irq = 1'b0;
  logic [3:0]  core_irq, core_fiq;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  core_irq_steer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_lvl(tmr_lvl), .mbox_pend(mbox_pend),
    .periph_irq(periph_irq), .periph_fiq(periph_fiq), .ltimer_irq(ltimer_irq),
    .core_irq(core_irq), .core_fiq(core_fiq));

  // {core1 timer ctl, core2 mbox ctl, tmr_lvl, mbox_pend, exp irq, exp fiq, pad}
  localparam logic [63:0] VEC [8] = '{
    {8'h01, 8'h00, 16'h0010, 16'h0000, 4'b0010, 4'b0000, 8'h00},
    {8'h11, 8'h00, 16'h0010, 16'h0000, 4'b0000, 4'b0010, 8'h00},
    {8'h00, 8'h00, 16'h00F0, 16'h0000, 4'b0000, 4'b0000, 8'h00},
    {8'h80, 8'h00, 16'h008F, 16'h0000, 4'b0000, 4'b0010, 8'h00},
    {8'h00, 8'h04, 16'h0000, 16'h0400, 4'b0100, 4'b0000, 8'h00},
    {8'h00, 8'h40, 16'h0000, 16'h0400, 4'b0000, 4'b0100, 8'h00},
    {8'h00, 8'h02, 16'h0000, 16'h0400, 4'b0000, 4'b0000, 8'h00},
    {8'h02, 8'h10, 16'h0020, 16'h0100, 4'b0010, 4'b0100, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rd(8'h0C, d); chk("R1 route", d, 0);
    rd(8'h40, d); chk("R1 tctl", d, 0);
    rd(8'h60, d); chk("R1 isrc", d, 0);
    chk("R1 outputs", {24'h0, core_irq, core_fiq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      wr(8'h44, {24'h0, VEC[i][63:56]});
      wr(8'h58, {24'h0, VEC[i][55:48]});
      tmr_lvl = VEC[i][47:32];
      mbox_pend = VEC[i][31:16];
      @(negedge clk);
      chk($sformatf("R2 R3 vec%0d irq", i), {28'h0, core_irq}, {28'h0, VEC[i][15:12]});
      chk($sformatf("R2 R3 vec%0d fiq", i), {28'h0, core_fiq}, {28'h0, VEC[i][11:8]});
    end
    rd(8'h64, d); chk("R2 core1 isrc bit1", d, 32'h2);
    rd(8'h78, d); chk("R3 core2 fsrc bit4", d, 32'h10);
    tmr_lvl = '0; mbox_pend = '0;

    wr(8'h44, 32'hFFFF_FF5A);
    rd(8'h44, d); chk("R6 byte mask", d, 32'h5A);

    wr(8'h0C, 32'hFFFF_FFFE);
    rd(8'h0C, d); chk("R4 route readback", d, 32'hE);
    periph_irq = 1'b1;
    #1 chk("R7 not yet", {28'h0, core_irq}, 0);
    @(negedge clk);
    chk("R7 R4 irq core2", {28'h0, core_irq}, 32'h4);
    rd(8'h68, d); chk("R4 core2 isrc", d, 32'h100);
    periph_irq = 1'b0; periph_fiq = 1'b1;
    @(negedge clk);
    chk("R4 fiq core3", {28'h0, core_fiq}, 32'h8);
    rd(8'h7C, d); chk("R4 core3 fsrc", d, 32'h100);
    periph_fiq = 1'b0;

    wr(8'h24, 32'h5);
    ltimer_irq = 1'b1;
    @(negedge clk);
    chk("R5 fiq core1", {24'h0, core_irq, core_fiq}, 32'h02);
    rd(8'h74, d); chk("R5 core1 fsrc", d, 32'h800);
    wr(8'h24, 32'h3);
    @(negedge clk);
    chk("R5 irq core3", {24'h0, core_irq, core_fiq}, 32'h80);
    rd(8'h6C, d); chk("R5 R8 core3 isrc", d, 32'h800);

    wr(8'h6C, 32'h0);
    rd(8'h6C, d); chk("R8 status write ignored", d, 32'h800);
    chk("R8 output kept", {28'h0, core_irq}, 32'h8);
    ltimer_irq = 1'b0;
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R8 unmapped read", d, 0);
    wr(8'h45, 32'h00);
    rd(8'h44, d); chk("R8 unaligned write ignored", d, 32'h5A);
    rd(8'h0C, d); chk("R8 route kept", d, 32'hE);
    @(negedge clk);
    chk("R7 outputs drop", {24'h0, core_irq, core_fiq}, 0);

    rst_n = 1'b0;
    @(negedge clk);
    rd(8'h24, d); chk("R1 lt route reset", d, 0);
    rd(8'h44, d); chk("R1 tctl reset", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule